// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow 16-bit host bus reach a bank of 64-bit internal registers that are spread over several functional blocks. The host sees a small window: a status register, an address register and four 16-bit data staging registers. Loading the address register is the only action that starts an internal transaction. Data register writes only fill the staging words.

A write transaction copies all four staged words into the selected wide register in one step. A read transaction fetches one 16-bit word of the selected register, picked by a two-bit index in the address. That word lands in data register 0 when the transaction ends. While a transaction runs, a busy flag in the status register is set for a fixed number of cycles. During that time the address and data registers are frozen. The status register also holds two host-controlled active-low reset outputs.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset, busy reads 0, both reset outputs are 0 (asserted), and the address and all four data registers read 0.
- R2: The status register (host_sel 0) reads busy in bit 0, the global reset output in bit 3 and the codec reset output in bit 4, with all other bits 0. Bits 3 and 4 can be written at any time. A write to bit 0 has no effect.
- R3: Writes to the data registers (host_sel 4..7 map to data words 0..3) while idle update only those registers and start no internal access.
- R4: A write to the address register (host_sel 1) while idle starts one transaction. Busy then reads 1 for exactly LATENCY cycles.
- R5: A write transaction (address bit 7 = 0) stores data words 0..3 as bits 15:0, 31:16, 47:32 and 63:48 of the selected register. The read-back index bits have no effect on a write.
- R6: A read transaction (address bit 7 = 1) places word number address[1:0] of the selected register into data register 0 as busy clears. Data words 1..3 are left unchanged.
- R7: Address fields select the register: bits 15:12 are the block type (1 = DMA port, 2 = clock generator, 3 = timer, 9 = global DMA control), bits 11:8 are the instance (valid from 1 to INSTS), and bits 3:2 are the parameter. Distinct registers hold independent values.
- R8: An address with an unknown type or an out-of-range instance still runs for LATENCY cycles. A write to it changes no register, and a read from it returns 0.
- R9: Address and data register writes made while busy are ignored.
- R10: The address register reads back the last accepted address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register select: 0 status, 1 address, 4..7 data words 0..3 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected host register (combinational) |
| glob_rst_n | output | 1 | Global reset output, active low, set from status bit 3 |
| codec_rst_n | output | 1 | Codec reset output, active low, set from status bit 4 |

## Verification
The bench counts busy cycles to check the exact transaction length; a counter off by one would show LATENCY plus or minus one. It sends a second address write and a data write while a transaction is in flight; a bridge that accepts them would relaunch, or would corrupt the word still being committed. It writes to unknown types, instance 0 and instances beyond the limit; a loose decoder would alias these onto real registers, which would then read back wrong. It also stages data without a launch and checks that the bank is untouched, and that a read disturbs only data word 0.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int DATA_W     = 16;
    localparam int NUM_WORDS  = 4;
    localparam int NUM_PARAMS = 4;
    localparam int NUM_TYPES  = 4;
    localparam int WIDE_W     = DATA_W * NUM_WORDS;

    // status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_GLOB  = 3;
    localparam int ST_CODEC = 4;

    // host register selects
    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_ADDR   = 3'd1;

    typedef enum logic [3:0] {
        BT_DMA_PORT   = 4'h1,
        BT_CLKGEN     = 4'h2,
        BT_TIMER      = 4'h3,
        BT_DMA_GLOBAL = 4'h9
    } block_e;

    typedef struct packed {
        logic [3:0] btype;
        logic [3:0] inst;
        logic       rd;
        logic [2:0] rsvd;
        logic [1:0] param;
        logic [1:0] rb_idx;
    } xfer_addr_t;

    typedef logic [NUM_WORDS-1:0][DATA_W-1:0] wide_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] slot;
    } slot_t;

    function automatic slot_t type_slot(input logic [3:0] t);
        slot_t s;
        s = '0;
        case (t)
            BT_DMA_PORT:   begin s.valid = 1'b1; s.slot = 2'd0; end
            BT_CLKGEN:     begin s.valid = 1'b1; s.slot = 2'd1; end
            BT_TIMER:      begin s.valid = 1'b1; s.slot = 2'd2; end
            BT_DMA_GLOBAL: begin s.valid = 1'b1; s.slot = 2'd3; end
            default:       s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ibr_ctrl.sv
module ibr_ctrl #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                cnt  <= CW'(LATENCY - 1);
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R1: reset leaves the sequencer idle
    a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !busy);

    // R4: a launch while idle raises busy
    a_r4_launch_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && launch) |=> busy);

    // R4: the last busy cycle ends the transaction
    a_r4_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R4: the countdown never exceeds the latency window
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CW'(LATENCY - 1)));

endmodule

// File: rtl/ibr_bank.sv
module ibr_bank
    import ibr_pkg::*;
#(
    parameter int INSTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_addr_t        cmd,
    input  logic              commit,
    input  wide_t             wdata,
    output logic [DATA_W-1:0] rd_word
);
    localparam int NREG = NUM_TYPES * INSTS * NUM_PARAMS;

    slot_t sl;
    logic  inst_ok;
    logic  hit;
    int    flat;
    wide_t q [NREG];
    logic  [NREG-1:0] esel;
    wide_t rd_q;

    always_comb begin
        sl      = type_slot(cmd.btype);
        inst_ok = (cmd.inst != 4'd0) && (int'(cmd.inst) <= INSTS);
        hit     = sl.valid && inst_ok;
        flat    = int'(sl.slot) * INSTS * NUM_PARAMS
                + (int'(cmd.inst) - 1) * NUM_PARAMS
                + int'(cmd.param);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        assign esel[g] = hit && (flat == g);

        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (commit && esel[g])
                q[g] <= wdata;
        end

        // R5: an entry changes only on a commit that selects it
        a_r5_entry_hold: assert property (@(posedge clk) disable iff (rst)
            !(commit && esel[g]) |=> $stable(q[g]));
    end

    always_comb begin
        rd_q = '0;
        for (int i = 0; i < NREG; i++)
            if (esel[i]) rd_q = q[i];
    end

    assign rd_word = rd_q[cmd.rb_idx];

    // R8: at most one entry is ever selected
    a_r8_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(esel));

endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
    import ibr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              launch,
    output xfer_addr_t        cmd,
    output wide_t             stage,
    output logic              glob_rst_n,
    output logic              codec_rst_n
);
    logic data_we;
    logic [DATA_W-1:0] word_q [NUM_WORDS];

    assign launch  = host_we && (host_sel == SEL_ADDR) && !busy;
    assign data_we = host_we && host_sel[2] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd         <= '0;
            glob_rst_n  <= 1'b0;
            codec_rst_n <= 1'b0;
        end else begin
            if (launch)
                cmd <= xfer_addr_t'(host_wdata);
            if (host_we && host_sel == SEL_STATUS) begin
                glob_rst_n  <= host_wdata[ST_GLOB];
                codec_rst_n <= host_wdata[ST_CODEC];
            end
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= '0;
            else if (g == 0 && done && cmd.rd)
                word_q[g] <= rd_word;
            else if (data_we && host_sel[1:0] == 2'(g))
                word_q[g] <= host_wdata;
        end
        assign stage[g] = word_q[g];

        if (g != 0) begin : g_hold
            // R9, R6: upper words stay frozen through a transaction
            a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
                busy |=> $stable(word_q[g]));
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_sel[2]) begin
            host_rdata = word_q[host_sel[1:0]];
        end else if (host_sel == SEL_ADDR) begin
            host_rdata = cmd;
        end else if (host_sel == SEL_STATUS) begin
            host_rdata[ST_BUSY]  = busy;
            host_rdata[ST_GLOB]  = glob_rst_n;
            host_rdata[ST_CODEC] = codec_rst_n;
        end
    end

    // R9, R10: the accepted address stays put while busy
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd));

    // R9: data word 0 changes during busy only through a read result
    a_r9_word0_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !(done && cmd.rd)) |=> $stable(word_q[0]));

endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
    import ibr_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int INSTS   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [2:0]  host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        glob_rst_n,
    output logic        codec_rst_n
);
    logic              launch;
    logic              busy;
    logic              done;
    xfer_addr_t        cmd;
    wide_t             stage;
    logic [DATA_W-1:0] rd_word;
    logic              commit;

    assign commit = done && !cmd.rd;

    ibr_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .busy        (busy),
        .done        (done),
        .rd_word     (rd_word),
        .launch      (launch),
        .cmd         (cmd),
        .stage       (stage),
        .glob_rst_n  (glob_rst_n),
        .codec_rst_n (codec_rst_n)
    );

    ibr_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    ibr_bank #(.INSTS(INSTS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .commit  (commit),
        .wdata   (stage),
        .rd_word (rd_word)
    );

    // R3: no commit happens outside a transaction
    a_r3_commit_in_xfer: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !commit);

endmodule

// File: tb/sim_indirect_reg_bridge.sv
module sim_indirect_reg_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int LAT   = 4;
    localparam int INSTS = 2;
    localparam int NREG  = 4 * INSTS * 4;
    localparam int NVEC  = 8;

    // {address, 64-bit value}; every entry is a write
    localparam logic [79:0] VEC [NVEC] = '{
        {16'h1104, 64'h1111_2222_3333_4444},
        {16'h2208, 64'hA5A5_0F0F_F0F0_5A5A},
        {16'h310C, 64'hFFFF_0000_FFFF_0001},
        {16'h9100, 64'h0123_4567_89AB_CDEF},
        {16'h1200, 64'h8000_0001_7FFE_C3C3},
        {16'h4100, 64'hDEAD_BEEF_CAFE_F00D},
        {16'h1300, 64'h1234_1234_1234_1234},
        {16'h1107, 64'h0F0E_0D0C_0B0A_0908}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        glob_rst_n;
    logic        codec_rst_n;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model [NREG];

    always #(CLK_PERIOD / 2) clk = ~clk;

    indirect_reg_bridge #(.LATENCY(LAT), .INSTS(INSTS)) u0 (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .glob_rst_n  (glob_rst_n),
        .codec_rst_n (codec_rst_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] s, input logic [15:0] d);
        host_sel   = s;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [15:0] v);
        host_sel = s;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [15:0] st;
        cyc = 0;
        rd_reg(3'd0, st);
        while (st[0]) begin
            cyc++;
            @(negedge clk);
            rd_reg(3'd0, st);
        end
    endtask

    task automatic run_xfer(input logic [15:0] a, output int cyc);
        host_write(3'd1, a);
        wait_idle(cyc);
    endtask

    function automatic int midx(input logic [15:0] a);
        int slot;
        int inst;
        case (a[15:12])
            4'h1: slot = 0;
            4'h2: slot = 1;
            4'h3: slot = 2;
            4'h9: slot = 3;
            default: slot = -1;
        endcase
        inst = int'(a[11:8]);
        if (slot < 0 || inst < 1 || inst > INSTS) return -1;
        return slot * INSTS * 4 + (inst - 1) * 4 + int'(a[3:2]);
    endfunction

    function automatic logic [15:0] mword(input logic [15:0] a, input int k);
        int i;
        logic [63:0] v;
        i = midx(a);
        if (i < 0) return 16'h0;
        v = model[i];
        return v[16*k +: 16];
    endfunction

    function automatic logic [15:0] rd_addr(input logic [15:0] a, input int k);
        return {a[15:8], 1'b1, 3'b000, a[3:2], 2'(k)};
    endfunction

    task automatic stage_wide(input logic [63:0] v);
        for (int k = 0; k < 4; k++)
            host_write(3'(4 + k), v[16*k +: 16]);
    endtask

    task automatic read_back(input logic [15:0] a, input string req);
        int cyc;
        logic [15:0] v;
        for (int k = 0; k < 4; k++) begin
            run_xfer(rd_addr(a, k), cyc);
            rd_reg(3'd4, v);
            chk(req, v, mword(a, k));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] a;
        logic [63:0] d;
        int cyc;

        for (int i = 0; i < NREG; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_reg(3'd0, v); chk("R1 status", v, 16'h0000);
        rd_reg(3'd1, v); chk("R1 addr", v, 16'h0000);
        for (int k = 0; k < 4; k++) begin
            rd_reg(3'(4 + k), v);
            chk("R1 data", v, 16'h0000);
        end
        chk("R1 reset pins", {14'h0, glob_rst_n, codec_rst_n}, 16'h0000);

        // R2: status bits, busy bit is read-only
        @(negedge clk);
        host_write(3'd0, 16'h0019);
        rd_reg(3'd0, v); chk("R2 status both released", v, 16'h0018);
        chk("R2 pins", {14'h0, glob_rst_n, codec_rst_n}, 16'h0003);
        host_write(3'd0, 16'h0008);
        rd_reg(3'd0, v); chk("R2 codec held", v, 16'h0008);
        chk("R2 codec pin", {15'h0, codec_rst_n}, 16'h0000);

        // R4: busy length on a single transaction
        run_xfer(16'h9180, cyc);
        chk("R4 busy cycles", 16'(cyc), 16'(LAT));

        // R5, R7, R8: vector table of writes, each read back by index (R6)
        for (int e = 0; e < NVEC; e++) begin
            a = VEC[e][79:64];
            d = VEC[e][63:0];
            stage_wide(d);
            run_xfer(a, cyc);
            chk("R4 write busy cycles", 16'(cyc), 16'(LAT));
            if (midx(a) >= 0) model[midx(a)] = d;
            read_back(a, "R5 R7 R8 readback");
        end
        // R7: earlier registers keep their own values
        read_back(16'h2208, "R7 independence");
        read_back(16'h1200, "R7 independence");
        // R8: instance 0 invalid
        stage_wide(64'h5555_6666_7777_8888);
        run_xfer(16'h1000, cyc);
        chk("R8 invalid busy cycles", 16'(cyc), 16'(LAT));
        read_back(16'h1000, "R8 instance zero");
        read_back(16'h1100, "R8 no alias");

        // R3: staging alone does not touch the bank
        stage_wide(64'h9999_AAAA_BBBB_CCCC);
        repeat (LAT + 2) @(negedge clk);
        read_back(16'h9100, "R3 staging only");
        // R6: a read leaves data words 1..3 alone
        rd_reg(3'd5, v); chk("R6 word1 kept", v, 16'hBBBB);
        rd_reg(3'd7, v); chk("R6 word3 kept", v, 16'h9999);
        // R10: address readback
        rd_reg(3'd1, v); chk("R10 addr readback", v, rd_addr(16'h9100, 3));

        // R9: writes while busy are ignored
        stage_wide(64'h4444_3333_2222_1111);
        host_write(3'd1, 16'h1108);
        host_write(3'd5, 16'hBAD0);
        host_write(3'd1, 16'h2104);
        wait_idle(cyc);
        model[midx(16'h1108)] = 64'h4444_3333_2222_1111;
        rd_reg(3'd1, v); chk("R9 addr not replaced", v, 16'h1108);
        rd_reg(3'd5, v); chk("R9 data not replaced", v, 16'h2222);
        @(negedge clk);
        rd_reg(3'd0, v); chk("R9 no relaunch", v, 16'h0008);
        read_back(16'h1108, "R9 committed staged value");
        read_back(16'h2104, "R9 second launch dropped");

        finish_run();
    end

endmodule